// File: doc/BRIEF.md
# Chained Multi-Limb Right Shifter

This block shifts a big integer right by 0 to 63 bit positions. The integer is stored as up to `MAX_LIMBS` 64-bit limbs in an array outside the block, with limb 0 the least significant. The block can do a logical shift or an arithmetic (sign-filling) shift. It reaches the array through one read port and one write port. It works on one limb per clock cycle. It starts at the most significant limb and writes each result back to the address it was read from.

Each step uses a double-width primitive. The primitive takes the limb with 64 zero bits appended and rotates this 128-bit value left by 128 minus the shift amount. The upper half of the rotated value is the limb shifted right. The lower half holds the bits that fell out, already placed at the top of a 64-bit word. That lower half becomes the carry for the next, less significant limb. The next limb keeps only the top n bit positions of the incoming carry and ORs them into its own shifted value. Before the first step the carry is seeded. For an arithmetic shift the seed is the sign bit of the top limb repeated across the word. For a logical shift the seed is zero.

A caller loads the array and sets the limb count, the shift amount and the mode. It then pulses `start` and waits for the one-cycle `done` pulse.

Top module: `bshr_chain`

## Requirements
- R1: After `start` is accepted with limb count K greater than 0, the block writes exactly K times, in K consecutive cycles. The write addresses go K-1, K-2, ..., 0. Limbs at addresses K and above are never written.
- R2: With `arith` = 0, the K limbs afterwards hold the unsigned value (limb K-1 down to limb 0, read as one 64·K-bit number) shifted right by `shiftAmt`. Zeros fill the vacated top bits.
- R3: With `arith` = 1, the vacated top `shiftAmt` bits of the 64·K-bit result equal bit 63 of limb K-1 as it was before the shift. All other bits match the logical shift.
- R4: With `shiftAmt` = 0, every limb is written back unchanged, in both modes.
- R5: `busy` is 1 in each cycle that performs a write. `done` is 1 for exactly one cycle: the cycle after the write to address 0. For K > 0 that is K+1 cycles after the clock edge that accepted `start`.
- R6: While the block is busy or signalling `done`, `start` is ignored. Holding it high does not restart the block or add writes.
- R7: A start with limb count 0 writes nothing and raises `done` in the next cycle.
- R8: While reset is active and after it is released, `busy`, `done` and `wrEn` are 0 until a start is accepted.
- R9: The shift amount and the mode are captured on the accepting edge. Changing `shiftAmt` or `arith` during a run does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a shift; accepted only when idle |
| limbCount | input | $clog2(MAX_LIMBS+1) | Number of limbs K to shift |
| shiftAmt | input | 6 | Right shift distance, 0..63 |
| arith | input | 1 | 1 = arithmetic (sign fill), 0 = logical |
| rdData | input | 64 | Limb at `rdAddr`, combinational read |
| busy | output | 1 | A limb step is in progress this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdAddr | output | $clog2(MAX_LIMBS) | Limb array read address |
| wrEn | output | 1 | Write strobe for the limb array |
| wrAddr | output | $clog2(MAX_LIMBS) | Limb array write address |
| wrData | output | 64 | Shifted limb to write |

## Verification
The assertions assume three things about the inputs. First, `rdData` returns the limb at `rdAddr` in the same cycle. Second, `limbCount` never exceeds `MAX_LIMBS`. Third, the array is changed only by the block's own writes while a run is in progress. The bench keeps within these assumptions as follows. It models the array with a combinational read. It loads new values only between runs. It sweeps limb counts 0 to 4 on a four-limb build, every shift amount and both modes. On some runs it holds `start` high and changes `shiftAmt` and `arith` in the middle of the run.

// File: rtl/bshr_pkg.sv
package bshr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch shift amount and mode
    logic stepEn;     // process one limb this cycle
    logic firstStep;  // seed the carry from the top limb
  } bshrStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bshrState_t;

endpackage

// File: rtl/bshr_limb_step.sv
module bshr_limb_step #(
  parameter int LIMB_W = 64,
  parameter int SHW    = $clog2(LIMB_W)
) (
  input  logic [LIMB_W-1:0] limbIn,
  input  logic [LIMB_W-1:0] carryIn,
  input  logic [SHW-1:0]    shAmt,
  output logic [LIMB_W-1:0] limbOut,
  output logic [LIMB_W-1:0] carryOut
);
  localparam int DW = 2 * LIMB_W;
  localparam int RW = SHW + 2;

  logic [DW-1:0] wideIn;
  logic [DW-1:0] rotated;
  logic [RW-1:0] rotAmt;
  logic [RW-1:0] backAmt;
  logic [LIMB_W-1:0] topMask;

  always_comb begin
    wideIn  = {limbIn, {LIMB_W{1'b0}}};
    rotAmt  = RW'(DW) - RW'(shAmt);
    backAmt = RW'(DW) - rotAmt;
    // left rotation by DW-n; a shift by DW yields zero
    rotated = (wideIn << rotAmt) | (wideIn >> backAmt);
    topMask = ~({LIMB_W{1'b1}} >> shAmt);
    limbOut  = rotated[DW-1:LIMB_W] | (carryIn & topMask);
    carryOut = rotated[LIMB_W-1:0];
  end

endmodule

// File: rtl/bshr_ctrl.sv
module bshr_ctrl
  import bshr_pkg::*;
#(
  parameter int MAX_LIMBS = 8,
  parameter int CNT_W     = $clog2(MAX_LIMBS + 1),
  parameter int AW        = (MAX_LIMBS > 1) ? $clog2(MAX_LIMBS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] limbCount,
  output bshrStrobe_t      strobe,
  output logic [AW-1:0]    limbAddr,
  output logic             busy,
  output logic             done
);
  bshrState_t state;
  logic [AW-1:0] idx;
  logic          first;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      first <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (limbCount == '0) begin
              state <= ST_DONE;
            end else begin
              state <= ST_RUN;
              idx   <= AW'(limbCount - CNT_W'(1));
              first <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          first <= 1'b0;
          if (idx == '0) state <= ST_DONE;
          else           idx   <= idx - AW'(1);
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture   = (state == ST_IDLE) && start;
    strobe.stepEn    = (state == ST_RUN);
    strobe.firstStep = (state == ST_RUN) && first;
    limbAddr = idx;
    busy     = (state == ST_RUN);
    done     = (state == ST_DONE);
  end

  // R5: done lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: the step on address 0 is followed by done
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (busy && limbAddr == '0) |=> done);

  // R1: addresses descend by one on every step after the first
  a_r1_descending: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && !strobe.firstStep) |-> (limbAddr == $past(limbAddr) - AW'(1)));

  // R6: a start seen mid-run does not break the walk
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && limbAddr != '0) |=> (busy && !strobe.firstStep));

  // R7: empty request finishes at once
  a_r7_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && limbCount == '0) |=> (done && !busy));

endmodule

// File: rtl/bshr_datapath.sv
module bshr_datapath
  import bshr_pkg::*;
#(
  parameter int LIMB_W = 64,
  parameter int SHW    = $clog2(LIMB_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bshrStrobe_t       strobe,
  input  logic [SHW-1:0]    shiftAmtIn,
  input  logic              arithIn,
  input  logic [LIMB_W-1:0] rdData,
  output logic [LIMB_W-1:0] wrData
);
  logic [SHW-1:0]    shiftReg;
  logic              arithReg;
  logic [LIMB_W-1:0] carryReg;
  logic [LIMB_W-1:0] carryIn;
  logic [LIMB_W-1:0] carryOut;
  logic [LIMB_W-1:0] seedCarry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      arithReg <= 1'b0;
      carryReg <= '0;
    end else begin
      if (strobe.capture) begin
        shiftReg <= shiftAmtIn;
        arithReg <= arithIn;
      end
      if (strobe.stepEn) carryReg <= carryOut;
    end
  end

  always_comb begin
    seedCarry = arithReg ? {LIMB_W{rdData[LIMB_W-1]}} : '0;
    carryIn   = strobe.firstStep ? seedCarry : carryReg;
  end

  bshr_limb_step #(.LIMB_W(LIMB_W), .SHW(SHW)) u_step (
    .limbIn  (rdData),
    .carryIn (carryIn),
    .shAmt   (shiftReg),
    .limbOut (wrData),
    .carryOut(carryOut)
  );

  // R4: zero shift passes each limb through
  a_r4_zero_pass: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && shiftReg == '0) |-> (wrData == rdData));

  // R2: logical top limb equals a plain right shift
  a_r2_top_logical: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.firstStep && !arithReg) |-> (wrData == (rdData >> shiftReg)));

  // R3: arithmetic top limb keeps its sign bit
  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.firstStep && arithReg) |-> (wrData[LIMB_W-1] == rdData[LIMB_W-1]));

  // R9: mode and amount hold still during a run
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && !strobe.firstStep) |-> ($stable(shiftReg) && $stable(arithReg)));

endmodule

// File: rtl/bshr_chain.sv
module bshr_chain
  import bshr_pkg::*;
#(
  parameter int MAX_LIMBS = 8,
  parameter int LIMB_W    = 64,
  localparam int SHW      = $clog2(LIMB_W),
  localparam int CNT_W    = $clog2(MAX_LIMBS + 1),
  localparam int AW       = (MAX_LIMBS > 1) ? $clog2(MAX_LIMBS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  limbCount,
  input  logic [SHW-1:0]    shiftAmt,
  input  logic              arith,
  input  logic [LIMB_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     rdAddr,
  output logic              wrEn,
  output logic [AW-1:0]     wrAddr,
  output logic [LIMB_W-1:0] wrData
);
  bshrStrobe_t strobe;
  logic [AW-1:0] limbAddr;

  bshr_ctrl #(.MAX_LIMBS(MAX_LIMBS), .CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .limbCount(limbCount),
    .strobe   (strobe),
    .limbAddr (limbAddr),
    .busy     (busy),
    .done     (done)
  );

  bshr_datapath #(.LIMB_W(LIMB_W), .SHW(SHW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .shiftAmtIn(shiftAmt),
    .arithIn   (arith),
    .rdData    (rdData),
    .wrData    (wrData)
  );

  assign rdAddr = limbAddr;
  assign wrAddr = limbAddr;
  assign wrEn   = strobe.stepEn;

  // R1 / R5: writes occur only while busy
  a_r1_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  // R8: nothing active straight after reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !wrEn));

endmodule

// File: tb/sim_bshr_chain.sv
module sim_bshr_chain;
  localparam int ML = 4;
  localparam int W  = ML * 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] limbCount = '0;
  logic [5:0] shiftAmt = '0;
  logic arith = 1'b0;
  logic [63:0] rdData;
  logic busy, done, wrEn;
  logic [1:0] rdAddr, wrAddr;
  logic [63:0] wrData;

  logic [63:0] mem [ML];
  int tests = 0;
  int fails = 0;
  int writeCount = 0;
  int expAddr = 0;
  bit orderBad = 1'b0;

  always #5 clk = ~clk;

  bshr_chain #(.MAX_LIMBS(ML)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .limbCount(limbCount),
    .shiftAmt(shiftAmt), .arith(arith), .rdData(rdData),
    .busy(busy), .done(done), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  assign rdData = mem[rdAddr];

  always @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
      if (int'(wrAddr) != expAddr) orderBad = 1'b1;
      expAddr = expAddr - 1;
      writeCount = writeCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runCase(input int k, input int n, input bit ar,
                         input bit disturb, input logic [W-1:0] val);
    logic [W-1:0] src, exp, got;
    int cyc;
    string tag;
    for (int i = 0; i < ML; i++) mem[i] = val[i*64 +: 64];
    src = '0;
    for (int b = 0; b < k * 64; b++) src[b] = val[b];
    exp = src >> n;
    if (ar && k > 0 && src[k*64-1])
      for (int b = 0; b < n; b++) exp[k*64-1-b] = 1'b1;
    for (int b = k * 64; b < W; b++) exp[b] = val[b];
    writeCount = 0;
    expAddr = k - 1;
    orderBad = 1'b0;
    @(negedge clk);
    start = 1'b1; limbCount = 3'(k); shiftAmt = 6'(n); arith = ar;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (disturb) begin
        shiftAmt = ~6'(n); arith = ~ar;   // R9 disturbance, start kept high (R6)
      end else begin
        start = 1'b0;
      end
    end while (!done && cyc < 20);
    start = 1'b0;
    for (int i = 0; i < ML; i++) got[i*64 +: 64] = mem[i];
    if (k == 0) tag = "R7";
    else if (disturb) tag = "R9/R6";
    else if (n == 0) tag = "R4";
    else if (ar) tag = "R3";
    else tag = "R2";
    check(got == exp, tag, got, exp);
    check(cyc == k + 1, "R5 done latency", W'(cyc), W'(k + 1));
    check(writeCount == k && !orderBad, "R1 write count/order",
          W'(writeCount), W'(k));
    @(negedge clk);
    check(!done && !busy, "R5 done single pulse", W'({done, busy}), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    for (int i = 0; i < ML; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wrEn, "R8 reset quiet", W'({busy, done, wrEn}), '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wrEn, "R8 after release", W'({busy, done, wrEn}), '0);

    for (int k = 1; k <= ML; k++)
      for (int n = 0; n < 64; n++)
        for (int ar = 0; ar < 2; ar++) begin
          for (int i = 0; i < ML; i++) v[i*64 +: 64] = {$urandom, $urandom};
          runCase(k, n, ar[0], (n % 7) == 3, v);
        end

    // R7: empty request leaves the array alone
    v = {ML{64'h0123_4567_89ab_cdef}};
    runCase(0, 5, 1'b1, 1'b0, v);
    // R3: all-ones negative value by 63 stays all ones
    runCase(ML, 63, 1'b1, 1'b0, {W{1'b1}});
    // R2: all ones logical by 63
    runCase(ML, 63, 1'b0, 1'b0, {W{1'b1}});
    // R3: only sign bit set, shift 63
    v = '0; v[W-1] = 1'b1;
    runCase(ML, 63, 1'b1, 1'b0, v);
    // R4: zero shift of negative value, arithmetic
    runCase(2, 0, 1'b1, 1'b0, {W{1'b1}});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule